// File: doc/BRIEF.md
# Periodic Tick Timer with Self-Acknowledging Flag

The block divides its input clock by a fixed ratio to produce a periodic tick. With the default ratio of 1,000,000 a 50 MHz clock gives 50 ticks per second. Each tick sets a sticky pending flag, and the flag drives a level interrupt output. Software controls the block through a single byte-wide register. That register holds an enable bit and the pending flag.

The register encoding lets an increment instruction in an interrupt handler act as a complete acknowledge. A pending read returns `0x80` or `0x82`. Adding one gives `0x81` or `0x83`. Writing that value back clears the flag through its write-1-to-clear bit and keeps the enable as it was. Bit 0 is a don't-care on write. Reads have no side effects, and the read data is a combinational view of the stored state.

Software writes the register with a one-cycle `wr_en` strobe. A write takes effect at the clock edge that samples the strobe. The bus interface is plain control, with no handshake.

Top module: `tick_timer`

## Requirements
- R1: After reset the register reads `0x00` and `irq` is low. An asserted reset at any time returns the block to this state.
- R2: Bit 1 is the enable. It takes the value of `wr_data[1]` on every write and reads back at bit 1.
- R3: A write with bit 7 at 0 (for example `0x01`, `0x02` or `0x03`) leaves the pending flag unchanged.
- R4: A write with bit 7 at 1 (for example `0x81` or `0x83`) clears the pending flag. In the same write, the enable takes `wr_data[1]`.
- R5: While enabled, the flag sets on every wrap of the prescaler. A write that enables the timer at clock edge E sets the flag at edge E+DIV. It sets again every DIV cycles after that.
- R6: If a tick and a clearing write fall on the same edge, the tick wins and the flag stays set.
- R7: Bits 6..2 and bit 0 always read 0, and writes to those bits have no effect.
- R8: `irq` is high exactly while the flag (read bit 7) is set.
- R9: Disabling the timer returns the prescaler to zero. The first tick after re-enabling comes a full DIV cycles later, not the remainder of the earlier count.
- R10: Writing back a pending read value plus one (`0x82` becoming `0x83`) lowers `irq`, leaves the timer enabled, and the next tick follows DIV cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock the prescaler divides |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register value: bit 7 flag, bit 1 enable |
| irq | output | 1 | Level interrupt, high while the flag is set |

## Verification
The encoding is exercised in two phases. First, a table of writes is applied with no flag pending. This separates the enable bit from the don't-care bit 0 and from the unused bits. Second, the same write values are applied while the flag is set. This shows which writes clear the flag and which leave it alone. Tick timing is measured to the exact edge in four situations: a fresh enable, a re-enable after a partial count, the increment-style acknowledge, and a clear that lands on the tick edge. These cases tell an off-by-one prescaler, a lost tick and a prescaler that keeps its count apart from the correct behaviour.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_BIT = 7;  // write-1-to-clear pending flag
  localparam int EN_BIT   = 1;  // enable; bit 0 is a don't-care on write

  function automatic logic [REG_W-1:0] pack_status(input logic flag, input logic en);
    logic [REG_W-1:0] v;
    v           = '0;
    v[FLAG_BIT] = flag;
    v[EN_BIT]   = en;
    return v;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tick_ctrl_reg.sv
module tick_ctrl_reg
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             tick,
  output logic             en,
  output logic             flag
);
  logic clr_req;
  assign clr_req = wr_en && wr_data[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (wr_en) en <= wr_data[EN_BIT];
      if (tick)         flag <= 1'b1;  // tick has priority over a clear
      else if (clr_req) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_readback.sv
module tick_readback
  import tick_timer_pkg::*;
(
  input  logic             en,
  input  logic             flag,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  assign rd_data = pack_status(flag, en);
  assign irq     = flag;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DIV = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  logic en_q;
  logic flag_q;
  logic tick_w;

  tick_prescaler #(.DIV(DIV)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (en_q),
    .tick (tick_w)
  );

  tick_ctrl_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .tick   (tick_w),
    .en     (en_q),
    .flag   (flag_q)
  );

  tick_readback u_rb (
    .en     (en_q),
    .flag   (flag_q),
    .rd_data(rd_data),
    .irq    (irq)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             irq,
  input logic             tick
);
  // R8: interrupt level mirrors the flag seen at the register
  a_r8_irq_is_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq == rd_data[FLAG_BIT]);

  // R7: unused bits read zero
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 8'h7D) == 8'h00);

  // R2: enable follows the written bit 1
  a_r2_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[EN_BIT] == $past(wr_data[EN_BIT]));

  // R3: a write without bit 7 keeps the flag, unless a tick sets it
  a_r3_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[FLAG_BIT] && !tick) |=> irq == $past(irq));

  // R4: a clearing write without a tick drops the flag
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[FLAG_BIT] && !tick) |=> !irq);

  // R6: a tick always leaves the flag set
  a_r6_tick_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> irq);

  // R5: the flag only rises on a tick
  a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));
endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .rd_data(rd_data),
  .irq    (irq),
  .tick   (tick_w)
);

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tick_timer #(.DIV(DIV)) u_tick_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  // {write value, expected read afterwards}; flag clear throughout
  localparam logic [15:0] VEC [8] = '{
    {8'h01, 8'h00}, {8'h02, 8'h02}, {8'h03, 8'h02}, {8'h7D, 8'h00},
    {8'h7E, 8'h02}, {8'h83, 8'h02}, {8'h81, 8'h00}, {8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (rd_data !== exp || irq !== exp[7]) begin
      errors++;
      $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
               req, rd_data, irq, exp, exp[7]);
    end
  endtask

  // called at a negedge; returns at the next negedge after the write edge
  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    check("R1 reset value", 8'h00);
    rst_n = 1'b1;
    wait_n(1);
    check("R1 after release", 8'h00);

    // R2 R3 R7: encoding table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][15:8]);
      check("R2/R3/R7 table", VEC[i][7:0]);
    end

    // R5: first tick exactly DIV edges after the enabling write
    wr(8'h02);
    wait_n(DIV - 1);
    check("R5 no tick early", 8'h02);
    wait_n(1);
    check("R5 tick on time", 8'h82);

    // R3: writes without bit 7 keep the flag
    wr(8'h03);
    check("R3 keep flag with 03", 8'h82);
    wr(8'h01);
    check("R3 keep flag, disable", 8'h80);
    wr(8'h7D);
    check("R7 unused bits ignored", 8'h80);
    // R4: clear and keep disabled
    wr(8'h81);
    check("R4 clear 81", 8'h00);

    // R10: increment acknowledge
    wr(8'h02);
    wait_n(DIV);
    check("R10 pending", 8'h82);
    wr(rd_data + 8'h01);
    check("R10 ack by increment", 8'h02);
    wait_n(DIV - 2);
    check("R10 no early tick", 8'h02);
    wait_n(1);
    check("R10 next tick on period", 8'h82);

    // R6: clear lands on the next tick edge
    wait_n(DIV - 1);
    wr(8'h83);
    check("R6 tick beats clear", 8'h82);
    wr(8'h83);
    check("R4 clear 83 keep enable", 8'h02);

    // R9: disable mid-count then re-enable
    wr(8'h00);
    wr(8'h81);
    wr(8'h02);
    wait_n(3);
    wr(8'h00);
    wr(8'h02);
    wait_n(DIV - 1);
    check("R9 restart no early tick", 8'h02);
    wait_n(1);
    check("R9 restart full period", 8'h82);

    // R1: reset mid-run with flag set
    rst_n = 1'b0;
    wait_n(1);
    check("R1 reset clears", 8'h00);
    rst_n = 1'b1;
    wait_n(DIV + 2);
    check("R1 stays disabled", 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule